// File: doc/BRIEF.md
# Delayed-Start Block DMA Engine

This block is a single-channel DMA engine that moves a block of 32-bit words between a small internal buffer memory and an external memory port. Software programs four registers: a source address, a destination address, a byte count and a command word. The command word holds three bits: run, direction and interrupt enable. Writing the command with the run bit set arms the engine. The engine then waits a fixed, parameterised number of clock cycles before it starts. Before it moves any data, it checks that the buffer-side range lies wholly inside the buffer window.

Every external address passes through an AND mask, which by default keeps the low 28 bits. Words cross the external port one per request/acknowledge handshake, in ascending address order. While the run bit is set, the register file refuses all writes. At the end of a transfer the engine clears the run bit. A successful transfer with interrupt enable set raises a sticky completion flag. A transfer that fails the range check raises a sticky error flag. Both flags stay set until they are acknowledged.

Top module: `delayed_dma`

## Requirements
- R1: While bit0 (run) of the command register is 1, writes to any of the four registers (select 0 source, 1 destination, 2 count, 3 command) are ignored, and read-back returns the earlier values.
- R2: A command write (select 3) with bit0 = 1 while idle arms a transfer. The first `ext_req` is seen exactly DELAY_CYCLES+1 clock cycles after the edge that captures the write. A command write with bit0 = 0 only stores bits 2..0 and starts nothing.
- R3: Command bit1 picks the direction, and `ext_we` equals bit1 during requests. With 0, data flows from external to buffer: source is the external address and destination is the buffer byte address. With 1, data flows from buffer to external: source is the buffer address and destination is the external address.
- R4: The external address of word i is (external register + 4*i) AND ADDR_MASK, with a default mask of 0x0FFF_FFFF.
- R5: Let b be the buffer-side byte address and n the count. The transfer runs only when b >= BUF_BASE (default 0x40000) and (b - BUF_BASE) + n <= BUF_BYTES (default 4096). Otherwise no request is issued, the run bit is cleared and `dma_err` is set.
- R6: The run bit (read-back bit0 of select 3) clears on the edge after the final acknowledged word. For an aborted or zero-length transfer it clears on the edge after the check. Bits 2..1 are kept.
- R7: A successful completion with command bit2 = 1 sets `dma_irq`. An abort never sets it.
- R8: A one-cycle `irq_ack` pulse clears both `dma_irq` and `dma_err`.
- R9: The count is in bytes, and count>>2 words move, one per cycle with `ext_req` and `ext_ack` both high. Word i uses buffer word (b - BUF_BASE)/4 + i. A count of 0 completes without any request.
- R10: After reset, all four registers read 0, `dma_irq` and `dma_err` are low, and `ext_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register written: 0 src, 1 dst, 2 count, 3 command |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_sel | input | 2 | Register read select, same encoding |
| reg_rd_data | output | 32 | Register read data (combinational) |
| ext_req | output | 1 | External word request |
| ext_we | output | 1 | 1 = write to external memory |
| ext_addr | output | 32 | Masked external byte address |
| ext_wdata | output | 32 | Word written to external memory |
| ext_rdata | input | 32 | Word read from external memory |
| ext_ack | input | 1 | Handshake acknowledge, one word per cycle |
| irq_ack | input | 1 | Clears completion and error flags |
| dma_irq | output | 1 | Sticky completion flag |
| dma_err | output | 1 | Sticky range-error flag |

## Verification
The bench builds the engine with DELAY_CYCLES = 7 and BUF_BYTES = 256, and keeps the default window base and the 28-bit mask. The short delay lets every transfer be timed to the exact cycle of its first request. The 64-word window lets the whole buffer be filled in one transfer, and lets random offsets and counts reach both the upper and lower window edges often. External addresses with high bits set show the mask at work, and a random acknowledge gap stresses the one-word-per-handshake rule.

// File: rtl/dlydma_pkg.sv
package dlydma_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CHECK, ST_MOVE} seq_st_t;

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CMD = 2'd3;

  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 1;
  localparam int CMD_IEN = 2;

  // external byte address of word number idx
  function automatic logic [31:0] ext_word_addr(input logic [31:0] base,
                                                input logic [31:0] idx,
                                                input logic [31:0] mask);
    return (base + (idx << 2)) & mask;
  endfunction

  // buffer-side range [baddr, baddr+nbytes) inside [wbase, wbase+wsize)
  function automatic logic window_fits(input logic [31:0] baddr,
                                       input logic [31:0] nbytes,
                                       input logic [31:0] wbase,
                                       input logic [31:0] wsize);
    logic [33:0] end_off;
    if (baddr < wbase) return 1'b0;
    end_off = {2'b00, baddr - wbase} + {2'b00, nbytes};
    return end_off <= {2'b00, wsize};
  endfunction

endpackage

// File: rtl/dlydma_regs.sv
module dlydma_regs
  import dlydma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        fin_evt,
  input  logic        abort_evt,
  input  logic        irq_ack,
  output logic [31:0] src_q,
  output logic [31:0] dst_q,
  output logic [31:0] cnt_q,
  output logic [2:0]  cmd_q,
  output logic        arm,
  output logic        irq_q,
  output logic        err_q
);

  logic running;
  logic wr_ok;

  assign running = cmd_q[CMD_RUN];
  assign wr_ok   = wr_en && !running;
  assign arm     = wr_ok && (wr_sel == SEL_CMD) && wr_data[CMD_RUN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      cmd_q <= '0;
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (wr_sel)
          SEL_SRC: src_q <= wr_data;
          SEL_DST: dst_q <= wr_data;
          SEL_CNT: cnt_q <= wr_data;
          default: cmd_q <= wr_data[2:0];
        endcase
      end
      if (fin_evt || abort_evt) cmd_q[CMD_RUN] <= 1'b0;
      if (irq_ack) begin
        irq_q <= 1'b0;
        err_q <= 1'b0;
      end
      if (fin_evt && cmd_q[CMD_IEN]) irq_q <= 1'b1;
      if (abort_evt) err_q <= 1'b1;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_SRC: rd_data = src_q;
      SEL_DST: rd_data = dst_q;
      SEL_CNT: rd_data = cnt_q;
      default: rd_data = {29'd0, cmd_q};
    endcase
  end

  // R1: a running transfer sees frozen registers
  assert_lockout_R1: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(src_q) && $stable(dst_q) && $stable(cnt_q) && $stable(cmd_q[2:1]));

  // R6: any end of transfer drops run on the next edge
  assert_runclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_evt || abort_evt) |=> !running);

  // R7: enabled completion raises the flag
  assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_evt && cmd_q[CMD_IEN]) |=> irq_q);

  // R5: abort sets the error flag
  assert_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> err_q);

  assert_events_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fin_evt, abort_evt, arm}));

endmodule

// File: rtl/dlydma_seq.sv
module dlydma_seq
  import dlydma_pkg::*;
#(
  parameter int          DELAY_CYCLES = 100000,
  parameter logic [31:0] ADDR_MASK    = 32'h0FFF_FFFF,
  parameter logic [31:0] BUF_BASE     = 32'h0004_0000,
  parameter int          BUF_BYTES    = 4096,
  localparam int         DEPTH        = BUF_BYTES / 4,
  localparam int         BIW          = $clog2(DEPTH),
  localparam int         WCW          = BIW + 1,
  localparam int         DLW          = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm,
  input  logic           dir,
  input  logic [31:0]    src_q,
  input  logic [31:0]    dst_q,
  input  logic [31:0]    cnt_q,
  output logic           ext_req,
  output logic           ext_we,
  output logic [31:0]    ext_addr,
  input  logic           ext_ack,
  output logic [BIW-1:0] buf_idx,
  output logic           buf_we,
  output logic           fin_evt,
  output logic           abort_evt
);

  seq_st_t        st;
  logic [DLW-1:0] dly_cnt;
  logic [WCW-1:0] word_idx;
  logic [WCW-1:0] nwords;
  logic [BIW-1:0] buf_first;
  logic [31:0]    bufside;
  logic [31:0]    extside;
  logic           fits;
  logic           last_word;
  logic           word_done;

  assign bufside   = dir ? src_q : dst_q;
  assign extside   = dir ? dst_q : src_q;
  assign fits      = window_fits(bufside, cnt_q, BUF_BASE, BUF_BYTES);
  assign nwords    = WCW'(cnt_q >> 2);
  assign buf_first = BIW'((bufside - BUF_BASE) >> 2);
  assign last_word = (word_idx == nwords - WCW'(1));

  assign ext_req   = (st == ST_MOVE);
  assign ext_we    = dir;
  assign ext_addr  = ext_word_addr(extside, 32'(word_idx), ADDR_MASK);
  assign word_done = ext_req && ext_ack;
  assign buf_idx   = buf_first + word_idx[BIW-1:0];
  assign buf_we    = word_done && !dir;

  assign abort_evt = (st == ST_CHECK) && !fits;
  assign fin_evt   = ((st == ST_CHECK) && fits && (nwords == '0)) || (word_done && last_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      dly_cnt  <= '0;
      word_idx <= '0;
    end else begin
      case (st)
        ST_IDLE: if (arm) begin
          st      <= ST_WAIT;
          dly_cnt <= '0;
        end
        ST_WAIT: begin
          if (dly_cnt == DLW'(DELAY_CYCLES - 1)) st <= ST_CHECK;
          else dly_cnt <= dly_cnt + DLW'(1);
        end
        ST_CHECK: begin
          word_idx <= '0;
          st       <= (fits && nwords != '0) ? ST_MOVE : ST_IDLE;
        end
        default: if (word_done) begin
          if (last_word) st <= ST_IDLE;
          else word_idx <= word_idx + WCW'(1);
        end
      endcase
    end
  end

  // R2: requests only ever begin right after the range check
  assert_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_req) |-> $past(st) == ST_CHECK);

  // R4: no address bit outside the mask
  assert_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> (ext_addr & ~ADDR_MASK) == 32'd0);

  // R9: each accepted word advances the address by one word (contiguous mask)
  assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !last_word) |=> ext_req && ext_addr == (($past(ext_addr) + 32'd4) & ADDR_MASK));

  // R5: an aborted transfer issues no request
  assert_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !ext_req);

endmodule

// File: rtl/dlydma_buf.sv
module dlydma_buf #(
  parameter int  DEPTH = 1024,
  localparam int BIW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [BIW-1:0] idx,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata
);

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/delayed_dma.sv
module delayed_dma
  import dlydma_pkg::*;
#(
  parameter int          DELAY_CYCLES = 100000,
  parameter logic [31:0] ADDR_MASK    = 32'h0FFF_FFFF,
  parameter logic [31:0] BUF_BASE     = 32'h0004_0000,
  parameter int          BUF_BYTES    = 4096,
  localparam int         DEPTH        = BUF_BYTES / 4,
  localparam int         BIW          = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_wr_sel,
  input  logic [31:0] reg_wr_data,
  input  logic [1:0]  reg_rd_sel,
  output logic [31:0] reg_rd_data,
  output logic        ext_req,
  output logic        ext_we,
  output logic [31:0] ext_addr,
  output logic [31:0] ext_wdata,
  input  logic [31:0] ext_rdata,
  input  logic        ext_ack,
  input  logic        irq_ack,
  output logic        dma_irq,
  output logic        dma_err
);

  logic [31:0]    src_q, dst_q, cnt_q;
  logic [2:0]     cmd_q;
  logic           arm, fin_evt, abort_evt;
  logic [BIW-1:0] buf_idx;
  logic           buf_we;

  dlydma_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
    .rd_sel(reg_rd_sel), .rd_data(reg_rd_data),
    .fin_evt(fin_evt), .abort_evt(abort_evt), .irq_ack(irq_ack),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .cmd_q(cmd_q),
    .arm(arm), .irq_q(dma_irq), .err_q(dma_err)
  );

  dlydma_seq #(
    .DELAY_CYCLES(DELAY_CYCLES), .ADDR_MASK(ADDR_MASK),
    .BUF_BASE(BUF_BASE), .BUF_BYTES(BUF_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .dir(cmd_q[CMD_DIR]),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_ack(ext_ack),
    .buf_idx(buf_idx), .buf_we(buf_we),
    .fin_evt(fin_evt), .abort_evt(abort_evt)
  );

  dlydma_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .we(buf_we), .idx(buf_idx),
    .wdata(ext_rdata), .rdata(ext_wdata)
  );

endmodule

// File: tb/delayed_dma_test.sv
module delayed_dma_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          DLY  = 7;
  localparam int          BUFB = 256;
  localparam int          NW   = BUFB / 4;
  localparam logic [31:0] BASE = 32'h0004_0000;
  localparam logic [31:0] MASK = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_sel = 2'd0;
  logic [31:0] reg_wr_data = 32'd0;
  logic [1:0]  reg_rd_sel = 2'd0;
  logic [31:0] reg_rd_data;
  logic        ext_req, ext_we;
  logic [31:0] ext_addr, ext_wdata;
  logic [31:0] ext_rdata = 32'd0;
  logic        ext_ack = 1'b0;
  logic        irq_ack = 1'b0;
  logic        dma_irq, dma_err;

  delayed_dma #(.DELAY_CYCLES(DLY), .BUF_BYTES(BUFB)) uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
    .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata), .ext_ack(ext_ack),
    .irq_ack(irq_ack), .dma_irq(dma_irq), .dma_err(dma_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] bmodel [NW];
  logic [31:0] seen_addr[$];
  logic [31:0] seen_data[$];
  logic        seen_we[$];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  function automatic bit exp_fits(input logic [31:0] b, input logic [31:0] n);
    longint off;
    if (b < BASE) return 1'b0;
    off = longint'(b) - longint'(BASE);
    return (off + longint'(n)) <= longint'(BUFB);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // external memory responder: random gaps, one-cycle acknowledge
  always @(negedge clk) begin
    if (!rst_n) ext_ack <= 1'b0;
    else if (ext_ack) ext_ack <= 1'b0;
    else if (ext_req && ($urandom % 3 != 0)) begin
      seen_addr.push_back(ext_addr);
      seen_we.push_back(ext_we);
      if (ext_we) seen_data.push_back(ext_wdata);
      else begin
        ext_rdata <= pat(ext_addr);
        seen_data.push_back(pat(ext_addr));
      end
      ext_ack <= 1'b1;
    end
  end

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] data);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] sel, output logic [31:0] val);
    reg_rd_sel = sel;
    #1;
    val = reg_rd_data;
  endtask

  task automatic ack_flags();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    #1;
    check("R8 irq cleared", {31'd0, dma_irq}, 32'd0);
    check("R8 err cleared", {31'd0, dma_err}, 32'd0);
  endtask

  task automatic do_xfer(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c,
                         input logic [2:0] cm, input bit poke);
    logic        dir;
    logic [31:0] bside, eside, v, ea, ed;
    bit          ok;
    int          nw, first, k, first_req;
    dir   = cm[1];
    bside = dir ? s : d;
    eside = dir ? d : s;
    ok    = exp_fits(bside, c);
    nw    = ok ? int'(c >> 2) : 0;
    first = ok ? int'((bside - BASE) >> 2) : 0;
    seen_addr.delete(); seen_data.delete(); seen_we.delete();
    reg_wr(2'd0, s); reg_wr(2'd1, d); reg_wr(2'd2, c); reg_wr(2'd3, cm);
    k = 0; first_req = -1;
    forever begin
      if (ext_req && first_req < 0) first_req = k;
      if (poke) begin
        if (k == 1) begin reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = ~s; end
        else if (k == 2) begin reg_wr_sel = 2'd3; reg_wr_data = 32'd0; end
        else if (k == 3) reg_wr_en = 1'b0;
      end
      reg_rd(2'd3, v);
      if (v[0] == 1'b0 || k > DLY + 8 * NW + 20) break;
      @(negedge clk);
      k++;
    end
    reg_wr_en = 1'b0;
    check("R6 run cleared, dir/ien kept", v, {29'd0, cm[2:1], 1'b0});
    if (ok && nw > 0) check("R2 start delay", 32'(first_req), 32'(DLY + 1));
    else check("R5/R9 no request issued", 32'(seen_addr.size()), 32'd0);
    check("R9 word count", 32'(seen_addr.size()), 32'(nw));
    for (int i = 0; i < nw && i < seen_addr.size(); i++) begin
      ea = (eside + 32'(4 * i)) & MASK;
      check("R4 masked address", seen_addr[i], ea);
      check("R3 write enable", {31'd0, seen_we[i]}, {31'd0, dir});
      if (dir) ed = bmodel[first + i];
      else begin
        ed = pat(ea);
        bmodel[first + i] = ed;
      end
      check("R3 data", seen_data[i], ed);
    end
    check("R5 error flag", {31'd0, dma_err}, {31'd0, !ok});
    check("R7 completion flag", {31'd0, dma_irq}, {31'd0, ok && cm[2]});
    if (poke) begin
      reg_rd(2'd0, v);
      check("R1 source locked", v, s);
    end
    ack_flags();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, bs, es, cn;
    logic        dr;
    int          offw, w;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    for (int sel = 0; sel < 4; sel++) begin
      reg_rd(2'(sel), v);
      check("R10 register reset", v, 32'd0);
    end
    check("R10 flags low", {30'd0, dma_irq, dma_err}, 32'd0);
    check("R10 no request", {31'd0, ext_req}, 32'd0);
    @(negedge clk);

    do_xfer(32'h0000_8000, BASE, 32'(BUFB), 3'b101, 1'b0);           // full window fill
    do_xfer(BASE, 32'hF123_4000, 32'(BUFB), 3'b011, 1'b0);           // R4 high bits masked
    do_xfer(32'hA000_0100, BASE + 32'(BUFB) - 8, 32'd8, 3'b101, 1'b0); // R5 top edge fits
    do_xfer(32'h0000_0200, BASE + 32'(BUFB) - 4, 32'd8, 3'b101, 1'b0); // R5 one word over
    do_xfer(BASE - 4, 32'h0000_0300, 32'd4, 3'b111, 1'b0);           // R5 below window
    do_xfer(32'h0000_0400, BASE, 32'd0, 3'b101, 1'b0);               // R9 zero count
    do_xfer(32'h0000_0500, BASE + 16, 32'd16, 3'b101, 1'b1);         // R1 lockout
    do_xfer(BASE + 16, 32'h0000_0600, 32'd16, 3'b111, 1'b0);         // read back R1 case

    // R2: command write with run clear starts nothing
    seen_addr.delete();
    reg_wr(2'd3, 32'h0000_0006);
    repeat (DLY + 6) @(negedge clk);
    #1;
    check("R2 no arm without run", 32'(seen_addr.size()), 32'd0);
    reg_rd(2'd3, v);
    check("R2 command stored", v, 32'd6);

    for (int t = 0; t < 24; t++) begin
      dr   = 1'($urandom % 2);
      offw = int'($urandom % (NW + 1));
      w    = int'($urandom % 17);
      cn   = 32'(4 * w);
      bs   = BASE + 32'(4 * offw);
      if ($urandom % 8 == 0) bs = BASE - 32'(4 * (1 + $urandom % 4));
      es   = $urandom & 32'hFFFF_FFFC;
      if (dr) do_xfer(bs, es, cn, {1'($urandom % 2), 1'b1, 1'b1}, 1'b0);
      else    do_xfer(es, bs, cn, {1'($urandom % 2), 1'b0, 1'b1}, 1'b0);
    end

    summary();
    $finish;
  end

endmodule